// File: doc/BRIEF.md
# Register File with Selectable Write Bus

This block is a storage array of `WORD_CNT` words, each `WORD_W` bits wide, with one write port and one read port that take separate addresses. The data written on a clock edge comes from one of two input buses, chosen by a select line. This lets a datapath store either of two results without an outside multiplexer.

Reads are combinational from the read address and are gated by a read enable. A build-time option turns word zero into a constant-zero register. Writes to that word are accepted and have no effect, and reads of it return zero. The array has no reset, so a word holds no defined value until it has been written.

Top module: `selbus_regfile`

## Requirements
- R1: On a rising clock edge with `wr_en`=1 and `wr_bus`=0, the word at `wr_addr` takes the value of `wr_data_a`.
- R2: On a rising clock edge with `wr_en`=1 and `wr_bus`=1, the word at `wr_addr` takes the value of `wr_data_b`.
- R3: On a clock edge with `wr_en`=0, no word changes, whatever the write address, bus select and data inputs are.
- R4: With `rd_en`=1, `rd_data` shows the word at `rd_addr` combinationally, with no clock edge needed.
- R5: With `rd_en`=0, `rd_data` is all zeros, including before any word has been written.
- R6: When a read and a write target the same address in the same cycle, `rd_data` shows the old value until the edge and the new value after it.
- R7: With `ZERO_WORD0`=1, a write to address 0 leaves the value read from address 0 unchanged.
- R8: With `ZERO_WORD0`=1, a read of address 0 returns all zeros at all times, including before any write.
- R9: With `ZERO_WORD0`=0, address 0 behaves as an ordinary writable word.
- R10: A write changes only the addressed word. Every other word keeps its value.
- R11: `WORD_CNT` must be a power of two and at least 2, and `WORD_W` must be at least 1. Any other value stops elaboration. The address width is log2(`WORD_CNT`).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. Writes happen on its rising edge |
| wr_bus | input | 1 | Write bus select: 0 takes `wr_data_a`, 1 takes `wr_data_b` |
| wr_en | input | 1 | Write enable, active high |
| rd_en | input | 1 | Read enable, active high. When low the output is zero |
| rd_addr | input | log2(WORD_CNT) | Read address |
| wr_addr | input | log2(WORD_CNT) | Write address |
| wr_data_a | input | WORD_W | Write bus 0 |
| wr_data_b | input | WORD_W | Write bus 1 |
| rd_data | output | WORD_W | Read data |

## Verification
The hardest case to reach from the ports is the read-during-write collision. The read must be sampled in the short window after the inputs settle and before the edge, and again just after the edge. The bench holds both addresses on one word with new data on the bus and takes one sample on each side of the edge. A second hard case is showing that a write left the other words untouched. After every single write in an exhaustive sweep over address and bus select, the bench reads back the whole array. It does this for two instances at once, one with the constant-zero word and one without.

// File: rtl/selbus_regfile_pkg.sv
package selbus_regfile_pkg;

   typedef enum logic {
      WBUS_A = 1'b0,
      WBUS_B = 1'b1
   } wbus_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/selbus_regfile_wsel.sv
module selbus_regfile_wsel
   import selbus_regfile_pkg::*;
#(
   parameter int WORD_W = 8
) (
   input  wbus_e              bus,
   input  logic [WORD_W-1:0]  data_a,
   input  logic [WORD_W-1:0]  data_b,
   output logic [WORD_W-1:0]  data_o
);

   always_comb begin
      unique case (bus)
         WBUS_A:  data_o = data_a;
         WBUS_B:  data_o = data_b;
         default: data_o = data_a;
      endcase
   end

endmodule

// File: rtl/selbus_regfile_wdec.sv
module selbus_regfile_wdec #(
   parameter int WORD_CNT   = 8,
   parameter bit ZERO_WORD0 = 1'b0,
   localparam int ADDR_W    = $clog2(WORD_CNT)
) (
   input  logic                 en,
   input  logic [ADDR_W-1:0]    addr,
   output logic [WORD_CNT-1:0]  strobe
);

   for (genvar i = 0; i < WORD_CNT; i++) begin : g_strobe
      if (ZERO_WORD0 && i == 0) begin : g_masked
         assign strobe[i] = 1'b0;
      end else begin : g_live
         assign strobe[i] = en && (addr == ADDR_W'(i));
      end
   end

endmodule

// File: rtl/selbus_regfile_word.sv
module selbus_regfile_word #(
   parameter int WORD_W    = 8,
   parameter bit HARD_ZERO = 1'b0
) (
   input  logic               clk,
   input  logic               we,
   input  logic [WORD_W-1:0]  d,
   output logic [WORD_W-1:0]  q
);

   if (HARD_ZERO) begin : g_const
      logic unused_word_in;
      assign unused_word_in = ^{clk, we, d};
      assign q = '0;
   end else begin : g_store
      logic [WORD_W-1:0] held;
      always_ff @(posedge clk) begin
         if (we) held <= d;
      end
      assign q = held;
   end

endmodule

// File: rtl/selbus_regfile_rmux.sv
module selbus_regfile_rmux #(
   parameter int WORD_W   = 8,
   parameter int WORD_CNT = 8,
   localparam int ADDR_W  = $clog2(WORD_CNT)
) (
   input  logic                              en,
   input  logic [ADDR_W-1:0]                 addr,
   input  logic [WORD_CNT-1:0][WORD_W-1:0]   words,
   output logic [WORD_W-1:0]                 data_o
);

   always_comb begin
      data_o = '0;
      if (en) data_o = words[addr];
   end

endmodule

// File: rtl/selbus_regfile.sv
module selbus_regfile
   import selbus_regfile_pkg::*;
#(
   parameter int WORD_W     = 8,
   parameter int WORD_CNT   = 8,
   parameter bit ZERO_WORD0 = 1'b0,
   localparam int ADDR_W    = $clog2(WORD_CNT)
) (
   input  logic               clk,
   input  logic               wr_bus,
   input  logic               wr_en,
   input  logic               rd_en,
   input  logic [ADDR_W-1:0]  rd_addr,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [WORD_W-1:0]  wr_data_a,
   input  logic [WORD_W-1:0]  wr_data_b,
   output logic [WORD_W-1:0]  rd_data
);

   // R11: parameter legality, checked at elaboration
   if (!is_pow2(WORD_CNT) || WORD_CNT < 2) begin : g_bad_cnt
      $error("selbus_regfile: WORD_CNT must be a power of two >= 2");
   end
   if (WORD_W < 1) begin : g_bad_w
      $error("selbus_regfile: WORD_W must be at least 1");
   end

   logic [WORD_W-1:0]                wdata;
   logic [WORD_CNT-1:0]              wstrb;
   logic [WORD_CNT-1:0][WORD_W-1:0]  words;

   selbus_regfile_wsel #(.WORD_W(WORD_W)) u_wsel (
      .bus    (wbus_e'(wr_bus)),
      .data_a (wr_data_a),
      .data_b (wr_data_b),
      .data_o (wdata)
   );

   selbus_regfile_wdec #(.WORD_CNT(WORD_CNT), .ZERO_WORD0(ZERO_WORD0)) u_wdec (
      .en     (wr_en),
      .addr   (wr_addr),
      .strobe (wstrb)
   );

   for (genvar i = 0; i < WORD_CNT; i++) begin : g_word
      selbus_regfile_word #(
         .WORD_W    (WORD_W),
         .HARD_ZERO (ZERO_WORD0 && i == 0)
      ) u_word (
         .clk (clk),
         .we  (wstrb[i]),
         .d   (wdata),
         .q   (words[i])
      );
   end

   selbus_regfile_rmux #(.WORD_W(WORD_W), .WORD_CNT(WORD_CNT)) u_rmux (
      .en     (rd_en),
      .addr   (rd_addr),
      .words  (words),
      .data_o (rd_data)
   );

endmodule

// File: rtl/selbus_regfile_chk.sv
module selbus_regfile_chk #(
   parameter int WORD_W     = 8,
   parameter int WORD_CNT   = 8,
   parameter bit ZERO_WORD0 = 1'b0,
   localparam int ADDR_W    = $clog2(WORD_CNT)
) (
   input logic               clk,
   input logic               wr_bus,
   input logic               wr_en,
   input logic               rd_en,
   input logic [ADDR_W-1:0]  rd_addr,
   input logic [ADDR_W-1:0]  wr_addr,
   input logic [WORD_W-1:0]  wr_data_a,
   input logic [WORD_W-1:0]  wr_data_b,
   input logic [WORD_W-1:0]  rd_data
);

   // no reset on this block: count edges so $past never reaches before time zero
   logic [1:0] age = 2'd0;
   always_ff @(posedge clk) begin
      if (age != 2'd3) age <= age + 2'd1;
   end

   p_rd_off_zero_r5: assert property (@(posedge clk) disable iff (age == 2'd0)
      !rd_en |-> (rd_data == '0));

   p_word0_zero_r8: assert property (@(posedge clk) disable iff (age == 2'd0)
      (ZERO_WORD0 && rd_en && rd_addr == '0) |-> (rd_data == '0));

   p_write_bus_a_r1: assert property (@(posedge clk) disable iff (age < 2'd2)
      ($past(wr_en) && !$past(wr_bus) && rd_en && rd_addr == $past(wr_addr)
       && !(ZERO_WORD0 && rd_addr == '0)) |-> (rd_data == $past(wr_data_a)));

   p_write_bus_b_r2: assert property (@(posedge clk) disable iff (age < 2'd2)
      ($past(wr_en) && $past(wr_bus) && rd_en && rd_addr == $past(wr_addr)
       && !(ZERO_WORD0 && rd_addr == '0)) |-> (rd_data == $past(wr_data_b)));

   p_no_write_hold_r3: assert property (@(posedge clk) disable iff (age < 2'd2)
      (!$past(wr_en) && $past(rd_en) && rd_en && rd_addr == $past(rd_addr))
      |-> (rd_data == $past(rd_data)));

endmodule

bind selbus_regfile selbus_regfile_chk #(
   .WORD_W     (WORD_W),
   .WORD_CNT   (WORD_CNT),
   .ZERO_WORD0 (ZERO_WORD0)
) u_chk (.*);

// File: tb/selbus_regfile_tb.sv
`timescale 1ns/1ps
module selbus_regfile_tb;
   localparam int W   = 8;
   localparam int CNT = 8;
   localparam int AW  = 3;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic          sel, wen, ren;
   logic [AW-1:0] adr, adw;
   logic [W-1:0]  d0, d1, q_n, q_z;
   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;
   logic [W-1:0] m_n [CNT];
   logic [W-1:0] m_z [CNT];

   selbus_regfile #(.WORD_W(W), .WORD_CNT(CNT), .ZERO_WORD0(1'b0)) u_dut (
      .clk(clk), .wr_bus(sel), .wr_en(wen), .rd_en(ren), .rd_addr(adr),
      .wr_addr(adw), .wr_data_a(d0), .wr_data_b(d1), .rd_data(q_n));

   selbus_regfile #(.WORD_W(W), .WORD_CNT(CNT), .ZERO_WORD0(1'b1)) u_dut_zero (
      .clk(clk), .wr_bus(sel), .wr_en(wen), .rd_en(ren), .rd_addr(adr),
      .wr_addr(adw), .wr_data_a(d0), .wr_data_b(d1), .rd_data(q_z));

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [W-1:0] pat_a(input int a, input int k);
      return W'(a * 37 + k * 11 + 5);
   endfunction

   function automatic logic [W-1:0] pat_b(input int a, input int k);
      return ~pat_a(a, k) ^ W'(k + 1);
   endfunction

   task automatic do_write(input int a, input bit s, input logic [W-1:0] x0,
                           input logic [W-1:0] x1, input bit e);
      @(negedge clk);
      adw = AW'(a); sel = s; d0 = x0; d1 = x1; wen = e;
      @(posedge clk);
      if (e) begin
         m_n[a] = s ? x1 : x0;
         if (a != 0) m_z[a] = s ? x1 : x0;
      end
      #1 wen = 1'b0;
   endtask

   task automatic read_both(input int a, input string rq_n, input string rq_z);
      @(negedge clk);
      adr = AW'(a); ren = 1'b1;
      #1;
      check(rq_n, q_n, m_n[a]);
      check(rq_z, q_z, (a == 0) ? '0 : m_z[a]);
   endtask

   task automatic read_all(input string rq);
      for (int a = 0; a < CNT; a++) begin
         if (a == 0) read_both(a, "R9", "R8");
         else        read_both(a, rq, rq);
      end
   endtask

   initial begin
      #(5.0 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not complete");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int k;
      sel = 0; wen = 0; ren = 0; adr = '0; adw = '0; d0 = '0; d1 = '0;
      #1;
      // R5: output gated low before any write
      check("R5", q_n, '0);
      check("R5", q_z, '0);
      // R8: word 0 reads zero before any write
      ren = 1'b1;
      #1;
      check("R8", q_z, '0);

      // fill every word once (R4 readback follows)
      for (int a = 0; a < CNT; a++) do_write(a, a[0], pat_a(a, 0), pat_b(a, 0), 1'b1);
      read_all("R4");

      // exhaustive address x bus sweep, full readback after each write
      k = 1;
      for (int a = 0; a < CNT; a++) begin
         for (int s = 0; s < 2; s++) begin
            do_write(a, s[0], pat_a(a, k), pat_b(a, k), 1'b1);
            if (a == 0) read_both(a, "R9", "R7");
            else        read_both(a, (s == 0) ? "R1" : "R2", (s == 0) ? "R1" : "R2");
            read_all("R10");
            k++;
         end
      end

      // R3: disabled writes change nothing
      for (int a = 0; a < CNT; a++) begin
         do_write(a, a[1], pat_a(a, 90), pat_b(a, 90), 1'b0);
         read_both(a, "R3", "R3");
      end
      read_all("R3");

      // R5: read enable low forces zero at every address
      for (int a = 0; a < CNT; a++) begin
         @(negedge clk);
         adr = AW'(a); ren = 1'b0;
         #1;
         check("R5", q_n, '0);
         check("R5", q_z, '0);
      end

      // R6: same-address read and write in one cycle
      @(negedge clk);
      adr = AW'(5); adw = AW'(5); ren = 1'b1; sel = 1'b0; wen = 1'b1;
      d0 = 8'hC3; d1 = 8'h3C;
      #1;
      check("R6", q_n, m_n[5]);
      check("R6", q_z, m_z[5]);
      @(posedge clk);
      #1;
      wen = 1'b0;
      m_n[5] = 8'hC3; m_z[5] = 8'hC3;
      check("R6", q_n, 8'hC3);
      check("R6", q_z, 8'hC3);

      // R7 collision on word 0 of the zero instance
      @(negedge clk);
      adr = '0; adw = '0; ren = 1'b1; sel = 1'b1; wen = 1'b1; d1 = 8'hFF;
      @(posedge clk);
      #1;
      wen = 1'b0;
      m_n[0] = 8'hFF;
      check("R7", q_z, '0);
      check("R9", q_n, 8'hFF);
      read_all("R10");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule